// File: doc/BRIEF.md
# PHY Management Serial Master

This block drives the two-wire serial management link to Ethernet PHYs. A request gives a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then produces a complete management frame on a divided-down clock output, together with a data output and an output-enable for an external tri-state pad. It also takes the pad's input level back in.

Each frame has a fixed length of 65 clock periods. It begins with a run of ones that brings every PHY on the link into step. The header follows: start pattern, opcode and the two addresses. After that comes either the write turnaround and data, or the released read window in which the PHY acknowledges and returns its register. Reads and writes have the same length, because the block keeps clocking through all data slots even when no PHY answers. The result of a read stays on the output until a later read replaces it. A one-cycle completion pulse marks the end of every frame.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `mdc`, `mdio_oe`, `mdio_o`, `busy`, `done`, `ack_fail` and `rd_data` are all zero.
- R2: A frame starts with 32 clock periods in which `mdio_oe`=1 and `mdio_o`=1.
- R3: The next 14 periods carry, MSB first and with `mdio_oe`=1: start bits 0,1; opcode 1,0 for a read (`req_write`=0) or 0,1 for a write (`req_write`=1); the 5-bit PHY address; the 5-bit register address.
- R4: A write then drives turnaround 1,0 and the 16 data bits MSB first. It drives one more period that holds the last data bit, and then releases `mdio_oe`. The frame has exactly 65 rising `mdc` edges.
- R5: A read drives a single 0 in period 46 (counting from 0). It then releases `mdio_oe` for the 18 remaining periods, which makes 65 rising edges in total.
- R6: In a read, the `mdio_i` level at the rising edge of period 47 is the acknowledge, where 0 means present. When the PHY acknowledges, the levels at the rising edges of periods 48 to 63 form `rd_data` MSB first and `ack_fail` is 0.
- R7: If the acknowledge level is 1, all 16 data periods and the trailing period are still clocked. At the end, `rd_data` is 0 and `ack_fail` is 1.
- R8: Each `mdc` half period lasts DIV_HALF system clocks, and the first high phase starts DIV_HALF clocks after a request is accepted. `mdio_o` and `mdio_oe` change only while `mdc` is low, and `mdc` stays low when no frame is active.
- R9: `busy` is high from the cycle after a request is accepted until the frame ends. `done` is high for exactly one cycle, 130*DIV_HALF clocks after acceptance, and `busy` falls in the same cycle.
- R10: A `req_valid` seen while `busy` is high is ignored: the frame in progress keeps its fields and no extra frame follows.
- R11: `rd_data` changes only when a read completes; it keeps its value through write frames and idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Last read result |
| ack_fail | output | 1 | Last frame was a read with no acknowledge |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value for the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Pad input level |

## Verification
The bench builds the block with DIV_HALF=3, so that each management period spans six system clocks and a whole frame takes 390 clocks. Because the half period is greater than one, the divider's counting variant is exercised. The bench can then check that the data pins stay steady through each high phase, and that the timing of the first high phase and of the completion pulse scales with the parameter. The bench also acts as a PHY that records every driven bit at the rising clock edge and answers reads, with and without an acknowledge. This brings the full frame contents, the released window and the no-acknowledge path into reach.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW    = 5;
  localparam int REG_AW    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int HDR_W     = 4 + PHY_AW + REG_AW;
  localparam int TA_SLOT   = PRE_LEN + HDR_W;
  localparam int DAT_SLOT  = TA_SLOT + 2;
  localparam int LAST_SLOT = DAT_SLOT + DATA_W;
  localparam int SLOT_W    = $clog2(LAST_SLOT + 1);

  typedef struct packed {
    logic              wr;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV_HALF = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  logic tick;
  logic mdc_q, mdc_d;

  generate
    if (DIV_HALF <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV_HALF);
      logic [CW-1:0] cnt_q, cnt_d;
      assign tick = run && (cnt_q == CW'(DIV_HALF - 1));
      always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_comb begin
    mdc_d = mdc_q;
    if (!run)      mdc_d = 1'b0;
    else if (tick) mdc_d = ~mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc_d;
  end

  assign mdc  = mdc_q;
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;

  assert_rise_sets_mdc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> mdc);
  assert_mdc_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  mdio_req_t         req,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_fail,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic              busy_q, busy_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  mdio_req_t         cur_q, cur_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              nack_q, nack_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              fail_q, fail_d;
  logic              done_q, done_d;
  logic              start, finish;
  logic [HDR_W-1:0]  hdr;
  logic [SLOT_W-1:0] hoff, doff;

  assign start  = req_valid && !busy_q;
  assign finish = busy_q && fall && (slot_q == SLOT_W'(LAST_SLOT));

  // next state
  always_comb begin
    busy_d  = busy_q;
    slot_d  = slot_q;
    cur_d   = cur_q;
    shift_d = shift_q;
    nack_d  = nack_q;
    rd_d    = rd_q;
    fail_d  = fail_q;
    done_d  = 1'b0;
    if (start) begin
      busy_d  = 1'b1;
      slot_d  = '0;
      cur_d   = req;
      shift_d = '0;
      nack_d  = 1'b0;
    end else if (busy_q) begin
      if (rise && !cur_q.wr) begin
        if (slot_q == SLOT_W'(DAT_SLOT - 1))
          nack_d = mdio_i;
        else if (slot_q >= SLOT_W'(DAT_SLOT) && slot_q < SLOT_W'(LAST_SLOT) && !nack_q)
          shift_d = {shift_q[DATA_W-2:0], mdio_i};
      end
      if (finish) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        fail_d = !cur_q.wr && nack_q;
        if (!cur_q.wr) rd_d = nack_q ? '0 : shift_q;
      end else if (fall) begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      slot_q  <= '0;
      cur_q   <= '0;
      shift_q <= '0;
      nack_q  <= 1'b0;
      rd_q    <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      slot_q  <= slot_d;
      cur_q   <= cur_d;
      shift_q <= shift_d;
      nack_q  <= nack_d;
      rd_q    <= rd_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
    end
  end

  // pad drive per slot
  assign hdr  = {2'b01, (cur_q.wr ? 2'b01 : 2'b10), cur_q.phy, cur_q.regad};
  assign hoff = slot_q - SLOT_W'(PRE_LEN);
  assign doff = slot_q - SLOT_W'(DAT_SLOT);

  always_comb begin
    mdio_oe = 1'b0;
    mdio_o  = 1'b0;
    if (busy_q) begin
      if (slot_q < SLOT_W'(PRE_LEN)) begin
        mdio_oe = 1'b1;
        mdio_o  = 1'b1;
      end else if (slot_q < SLOT_W'(TA_SLOT)) begin
        mdio_oe = 1'b1;
        mdio_o  = hdr[4'(HDR_W - 1) - hoff[3:0]];
      end else if (cur_q.wr) begin
        mdio_oe = 1'b1;
        if (slot_q == SLOT_W'(TA_SLOT))          mdio_o = 1'b1;
        else if (slot_q == SLOT_W'(TA_SLOT + 1)) mdio_o = 1'b0;
        else if (slot_q < SLOT_W'(LAST_SLOT))    mdio_o = cur_q.wdata[4'(DATA_W - 1) - doff[3:0]];
        else                                     mdio_o = cur_q.wdata[0];
      end else if (slot_q == SLOT_W'(TA_SLOT)) begin
        mdio_oe = 1'b1;
        mdio_o  = 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_data  = rd_q;
  assign ack_fail = fail_q;

  assert_pins_steady_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_nack_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && fail_q) |-> (rd_q == '0));
  assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (slot_q <= SLOT_W'(LAST_SLOT)));
  assert_rd_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(rd_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PHY_AW-1:0] req_phy,
  input  logic [REG_AW-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_fail,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic      rise, fall, busy_w;
  mdio_req_t req;

  assign req   = '{wr: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};
  assign busy  = busy_w;

  mdio_mdc_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_w),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio_frame_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req      (req),
    .rise     (rise),
    .fall     (fall),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .busy     (busy_w),
    .done     (done),
    .rd_data  (rd_data),
    .ack_fail (ack_fail),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int H = 3;
  localparam int NV = 6;
  // {write, nack, phy[4:0], reg[4:0], data[15:0]}
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'h01, 5'h00, 16'hA5C3},
    {1'b0, 1'b0, 5'h1F, 5'h1F, 16'h8001},
    {1'b0, 1'b1, 5'h00, 5'h02, 16'hFFFF},
    {1'b1, 1'b0, 5'h1F, 5'h15, 16'h0000},
    {1'b0, 1'b0, 5'h0A, 5'h11, 16'h1234},
    {1'b1, 1'b0, 5'h10, 5'h01, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, ack_fail, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i;

  int checks = 0, errors = 0;
  int rises = 0;
  logic cap_o [65];
  logic cap_oe [65];
  logic phy_nack = 1'b0;
  logic [15:0] phy_data = '0;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV_HALF(H)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .ack_fail(ack_fail),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // PHY model
  always_comb begin
    if (rises == 47)                    mdio_i = phy_nack;
    else if (rises >= 48 && rises < 64) mdio_i = phy_data[15 - (rises - 48)];
    else                                mdio_i = 1'b1;
  end

  always @(posedge mdc) begin
    if (rises < 65) begin
      cap_o[rises]  = mdio_o;
      cap_oe[rises] = mdio_oe;
    end
    rises = rises + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [27:0] v, input int s);
    logic [13:0] hdr;
    hdr = {2'b01, (v[27] ? 2'b01 : 2'b10), v[25:21], v[20:16]};
    if (s < 32) return 1'b1;
    if (s < 46) return hdr[13 - (s - 32)];
    if (v[27]) begin
      if (s == 46) return 1'b1;
      if (s == 47) return 1'b0;
      if (s < 64)  return v[15 - (s - 48)];
      return v[0];
    end
    return 1'b0;
  endfunction

  function automatic logic exp_oe(input logic [27:0] v, input int s);
    if (v[27] || s <= 46) return 1'b1;
    return 1'b0;
  endfunction

  logic [15:0] exp_rd = '0;

  task automatic run_frame(input logic [27:0] v, input bit poke_busy);
    int cyc, first_hi, bad_pre, bad_hdr, bad_tail, bad_oe, last_done;
    rises = 0;
    phy_nack = v[26];
    phy_data = v[15:0];
    @(negedge clk);
    req_valid = 1'b1; req_write = v[27]; req_phy = v[25:21];
    req_reg = v[20:16]; req_wdata = v[15:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 1);
    cyc = 0; first_hi = -1;
    while (done !== 1'b1 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (first_hi < 0 && mdc === 1'b1) first_hi = cyc;
      if (poke_busy && cyc == 50) begin
        req_valid = 1'b1; req_write = ~v[27]; req_phy = ~v[25:21];
        req_reg = ~v[20:16]; req_wdata = ~v[15:0];
      end
      if (poke_busy && cyc == 51) req_valid = 1'b0;
      if (cyc < 130*H) chk(busy === 1'b1 || cyc == 130*H, "R9 busy held", 32'(busy), 1);
    end
    chk(cyc == 130*H, "R9 done timing", 32'(cyc), 32'(130*H));
    chk(busy === 1'b0, "R9 busy falls with done", 32'(busy), 0);
    chk(first_hi == H, "R8 first high phase", 32'(first_hi), 32'(H));
    last_done = cyc;
    bad_pre = 0; bad_hdr = 0; bad_tail = 0; bad_oe = 0;
    for (int s = 0; s < 65; s++) begin
      if (cap_oe[s] !== exp_oe(v, s)) bad_oe++;
      if (exp_oe(v, s) && cap_o[s] !== exp_bit(v, s)) begin
        if (s < 32) bad_pre++;
        else if (s < 46) bad_hdr++;
        else bad_tail++;
      end
    end
    chk(bad_pre == 0, "R2 preamble ones", 32'(bad_pre), 0);
    chk(bad_hdr == 0, "R3 start/op/addr bits", 32'(bad_hdr), 0);
    if (v[27]) begin
      chk(bad_tail == 0, "R4 turnaround/data/idle bits", 32'(bad_tail), 0);
      chk(bad_oe == 0, "R4 write enable pattern", 32'(bad_oe), 0);
    end else begin
      chk(bad_tail == 0, "R5 read idle low bit", 32'(bad_tail), 0);
      chk(bad_oe == 0, "R5 read release pattern", 32'(bad_oe), 0);
    end
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", 32'(done), 0);
    chk(mdio_oe === 1'b0 && mdc === 1'b0, "R8 idle mdc low and released", {30'd0, mdc, mdio_oe}, 0);
    repeat (4*H) @(negedge clk);
    chk(rises == 65, v[26] ? "R7 nack still 65 clocks" : "R4 65 clocks", 32'(rises), 65);
    if (poke_busy) chk(busy === 1'b0 && rises == 65, "R10 busy request ignored", 32'(busy), 0);
    if (!v[27]) begin
      exp_rd = v[26] ? 16'h0 : v[15:0];
      if (v[26]) begin
        chk(rd_data === 16'h0, "R7 nack data zero", 32'(rd_data), 0);
        chk(ack_fail === 1'b1, "R7 ack_fail set", 32'(ack_fail), 1);
      end else begin
        chk(rd_data === v[15:0], "R6 read data", 32'(rd_data), 32'(v[15:0]));
        chk(ack_fail === 1'b0, "R6 ack ok", 32'(ack_fail), 0);
      end
    end else begin
      chk(rd_data === exp_rd, "R11 rd_data kept over write", 32'(rd_data), 32'(exp_rd));
      chk(ack_fail === 1'b0, "R4 write ack_fail clear", 32'(ack_fail), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0 && mdio_o === 1'b0, "R1 pins in reset",
        {29'd0, mdc, mdio_oe, mdio_o}, 0);
    chk(busy === 1'b0 && done === 1'b0, "R1 status in reset", {30'd0, busy, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd_data === 16'h0 && ack_fail === 1'b0, "R1 results after reset", {15'd0, ack_fail, rd_data}, 0);
    chk(mdc === 1'b0 && busy === 1'b0, "R1 idle after reset", {30'd0, mdc, busy}, 0);
    for (int i = 0; i < NV; i++) run_frame(VEC[i], 1'b0);
    // directed: request while busy on a read, then a write after it
    run_frame({1'b0, 1'b0, 5'h15, 5'h0A, 16'h5AA5}, 1'b1);
    run_frame({1'b1, 1'b0, 5'h03, 5'h1C, 16'h0F0F}, 1'b1);
    chk(rd_data === 16'h5AA5, "R11 rd_data after poke write", 32'(rd_data), 32'h5AA5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule